// File: doc/BRIEF.md
# Two-Tier Memory Error Logger

This block keeps a record of hardware error events raised by a memory controller. Two sources feed it. One is an uncorrectable or parity fault seen on a DRAM write. The other is a status that a hardware DRAM test has finished, which is not an error. When the first-capture register is empty, an event is stored there, and that register then stays frozen until software empties it. Events that arrive while the first-capture register holds anything are OR-ed into an accumulate register, so earlier bits are never lost. A per-source mask register stops an event from being logged. Every event that is logged produces a one-cycle non-fatal indication for a system-level error collector.

Software reaches the three registers through a plain address/write-data/read-data port. A write takes effect on the clock edge, and the read data is combinational from the address. The port accepts a write on every cycle and has no back-pressure, so a write can never be held off. The event inputs are single-cycle strobes that are sampled on every edge, and they likewise cannot be stalled. There are two resets. The power-on reset clears everything. The warm reset clears only the mask and the indication, and it leaves logged bits alone. While warm reset is held, events and writes are ignored.

Top module: `elog_unit`

## Requirements
- R1: After power-on reset, reads of the first-capture (address 0), accumulate (address 1) and mask (address 2) registers return 0000h, and `nf_err` is low.
- R2: An unmasked event that arrives while the first-capture register is zero sets its bit there: bit 7 for test-complete, bit 6 for write error. Events that arrive in the same cycle are all captured together. The first-capture register does not change while it is non-zero, except through software clears.
- R3: An unmasked event that arrives while the first-capture register is non-zero sets its bit in the accumulate register. Bits already set there stay set.
- R4: Writing a one to bit 7 or bit 6 at address 0 or 1 clears that bit, and writing a zero leaves it unchanged. All other bits, and every bit at address 3, read as zero and ignore writes.
- R5: If hardware sets a bit in the same cycle that software writes one to clear that bit, the bit ends up set.
- R6: Warm reset leaves the first-capture and accumulate registers unchanged and clears the mask register to zero.
- R7: The mask register (address 2) is read/write on bits 7 and 6, and its other bits read zero. A mask bit of one stops the matching event from being logged in either register and from raising `nf_err`.
- R8: A write error flagged as coming from the diagnostic injection path (`evt_wr_inj` high) is never logged.
- R9: `nf_err` is high for exactly the cycle after an edge at which at least one event was logged, and it is the only indication raised. Every logged event is non-fatal.
- R10: Once the first-capture register has been cleared to zero, the next logged event is captured there again, not in the accumulate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| warm_rst | input | 1 | Warm reset, synchronous, active high; clears the mask and `nf_err` only |
| evt_test_done | input | 1 | Strobe: hardware DRAM test finished |
| evt_wr_err | input | 1 | Strobe: uncorrectable/parity fault seen on a DRAM write, in any ECC mode |
| evt_wr_inj | input | 1 | Qualifier: the current write fault came from diagnostic injection |
| reg_addr | input | 2 | Register select: 0 first-capture, 1 accumulate, 2 mask, 3 unused |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data; write-one-to-clear at addresses 0 and 1 |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| nf_err | output | 1 | One-cycle non-fatal indication of a logged event |

## Verification
The event sequences cover a lone first event, a later event of a different source, and a repeat of a source that is already recorded. Together these separate the frozen first-capture register from the accumulating one. Two further sequences are a diagnostic-injected write fault and a pair of events in the same cycle. A software clear that lands on the same edge as an event, once with the target register empty and once with it busy, shows whether the set or the clear has priority. A fully masked pair of events, and an event right after a warm reset, show that the mask blocks logging and that warm reset clears the mask while the logged bits remain.

// File: rtl/elog_pkg.sv
package elog_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int BIT_TDONE = 7;
  localparam int BIT_WERR  = 6;

  typedef logic [REG_W-1:0] reg_t;

  localparam reg_t IMPL_BITS = (reg_t'(1) << BIT_TDONE) | (reg_t'(1) << BIT_WERR);

  localparam logic [ADDR_W-1:0] A_FIRST = 2'd0;
  localparam logic [ADDR_W-1:0] A_NEXT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 2'd2;
endpackage

// File: rtl/elog_src_qual.sv
module elog_src_qual #(
  parameter int W      = 16,
  parameter int TD_BIT = 7,
  parameter int WE_BIT = 6
) (
  input  logic         enable,
  input  logic         evt_test_done,
  input  logic         evt_wr_err,
  input  logic         evt_wr_inj,
  input  logic [W-1:0] mask,
  output logic [W-1:0] ev
);
  always_comb begin
    ev = '0;
    ev[TD_BIT] = evt_test_done;
    ev[WE_BIT] = evt_wr_err & ~evt_wr_inj;
    ev = ev & ~mask;
    if (!enable) ev = '0;
  end
endmodule

// File: rtl/elog_w1c_reg.sv
module elog_w1c_reg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // hardware set dominates a same-cycle software clear
  always_ff @(posedge clk) begin
    if (por_rst) q <= '0;
    else         q <= ((q & ~clr) | set) & IMPL;
  end
endmodule

// File: rtl/elog_unit.sv
module elog_unit
  import elog_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          warm_rst,
  input  logic          evt_test_done,
  input  logic          evt_wr_err,
  input  logic          evt_wr_inj,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wen,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          nf_err
);
  localparam int NREG = 2;
  localparam logic [RW-1:0] IMPL = RW'(IMPL_BITS);

  logic          active;
  logic          wr_ok;
  logic [RW-1:0] ev;
  logic [RW-1:0] mask_q;
  logic [RW-1:0] first_q;
  logic [RW-1:0] next_q;
  logic          first_busy;
  logic          nf_q;

  logic [RW-1:0] set_v [NREG];
  logic [RW-1:0] clr_v [NREG];
  logic [RW-1:0] q_v   [NREG];

  assign active = ~warm_rst;
  assign wr_ok  = reg_wen & active;

  elog_src_qual #(.W(RW), .TD_BIT(BIT_TDONE), .WE_BIT(BIT_WERR)) u_qual (
    .enable        (active),
    .evt_test_done (evt_test_done),
    .evt_wr_err    (evt_wr_err),
    .evt_wr_inj    (evt_wr_inj),
    .mask          (mask_q),
    .ev            (ev)
  );

  assign first_busy = |first_q;

  // index 0: first-capture, index 1: accumulate
  assign set_v[0] = first_busy ? '0 : ev;
  assign set_v[1] = first_busy ? ev : '0;
  assign clr_v[0] = (wr_ok && reg_addr == AW'(A_FIRST)) ? reg_wdata : '0;
  assign clr_v[1] = (wr_ok && reg_addr == AW'(A_NEXT))  ? reg_wdata : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_log
    elog_w1c_reg #(.W(RW), .IMPL(IMPL)) u_reg (
      .clk     (clk),
      .por_rst (por_rst),
      .set     (set_v[g]),
      .clr     (clr_v[g]),
      .q       (q_v[g])
    );
  end

  assign first_q = q_v[0];
  assign next_q  = q_v[1];

  always_ff @(posedge clk) begin
    if (por_rst || warm_rst)                     mask_q <= '0;
    else if (wr_ok && reg_addr == AW'(A_MASK))   mask_q <= reg_wdata & IMPL;
  end

  always_ff @(posedge clk) begin
    if (por_rst || warm_rst) nf_q <= 1'b0;
    else                     nf_q <= |ev;
  end

  assign nf_err = nf_q;

  always_comb begin
    unique case (reg_addr)
      AW'(A_FIRST): reg_rdata = first_q;
      AW'(A_NEXT):  reg_rdata = next_q;
      AW'(A_MASK):  reg_rdata = mask_q;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/elog_chk.sv
module elog_chk
  import elog_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          por_rst,
  input logic          warm_rst,
  input logic          evt_test_done,
  input logic          evt_wr_err,
  input logic          evt_wr_inj,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wen,
  input logic [RW-1:0] first_q,
  input logic [RW-1:0] next_q,
  input logic [RW-1:0] mask_q,
  input logic          nf_err
);
  localparam logic [RW-1:0] IMPL = RW'(IMPL_BITS);

  a_r2_first_frozen: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (first_q != '0 && !(reg_wen && reg_addr == AW'(A_FIRST))) |=> first_q == $past(first_q));

  a_r3_next_keeps: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    !(reg_wen && reg_addr == AW'(A_NEXT)) |=> ($past(next_q) & ~next_q) == '0);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (por_rst)
    ((first_q | next_q | mask_q) & ~IMPL) == '0);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (first_q != '0 && evt_test_done && !mask_q[BIT_TDONE]) |=> next_q[BIT_TDONE]);

  a_r6_warm_keeps: assert property (@(posedge clk) disable iff (por_rst)
    warm_rst |=> (first_q == $past(first_q) && next_q == $past(next_q)));

  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (first_q == '0 && mask_q == IMPL) |=> first_q == '0);

  a_r8_inject_excluded: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    (first_q == '0 && evt_wr_err && evt_wr_inj) |=> !first_q[BIT_WERR]);

  a_r9_nf_logged: assert property (@(posedge clk) disable iff (por_rst || warm_rst)
    nf_err |-> (first_q | next_q) != '0);
endmodule

bind elog_unit elog_chk #(.RW(RW), .AW(AW)) u_chk (
  .clk           (clk),
  .por_rst       (por_rst),
  .warm_rst      (warm_rst),
  .evt_test_done (evt_test_done),
  .evt_wr_err    (evt_wr_err),
  .evt_wr_inj    (evt_wr_inj),
  .reg_addr      (reg_addr),
  .reg_wen       (reg_wen),
  .first_q       (first_q),
  .next_q        (next_q),
  .mask_q        (mask_q),
  .nf_err        (nf_err)
);

// File: tb/tb_elog_unit.sv
module tb_elog_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic        td;
    logic        we;
    logic        inj;
    logic        wen;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp_first;
    logic [15:0] exp_next;
    logic        exp_nf;
  } vec_t;

  // td, we, inj, wen, addr, wdata, first, next, nf
  localparam vec_t VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0080, 16'h0000, 1'b1}, // R2 first capture
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0080, 16'h0040, 1'b1}, // R3 into accumulate
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0080, 16'h00C0, 1'b1}, // R3 keeps earlier bit
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0040, 16'h0080, 16'h0080, 1'b0}, // R4 write-one clears
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 16'hFF3F, 16'h0080, 16'h0080, 1'b0}, // R4 zeros/reserved no effect
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0080, 16'h0000, 16'h0080, 1'b0}, // R4 clear first
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0000, 16'h0000, 16'h0080, 1'b0}, // R8 injected ignored
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 16'h0040, 16'h0080, 1'b1}, // R10 recapture in first
    {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0080, 16'h0040, 16'h0080, 1'b1}, // R5 set beats clear, accumulate
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'hFFFF, 16'h0040, 16'h0000, 1'b0}, // R4 clear all accumulate
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0040, 16'h0000, 16'h0000, 1'b0}, // R4 clear first
    {1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 16'h0040, 16'h0040, 16'h0000, 1'b1}  // R5 set beats clear, first
  };

  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        evt_test_done = 1'b0;
  logic        evt_wr_err = 1'b0;
  logic        evt_wr_inj = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        nf_err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elog_unit dut (
    .clk           (clk),
    .por_rst       (por_rst),
    .warm_rst      (warm_rst),
    .evt_test_done (evt_test_done),
    .evt_wr_err    (evt_wr_err),
    .evt_wr_inj    (evt_wr_inj),
    .reg_addr      (reg_addr),
    .reg_wen       (reg_wen),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .nf_err        (nf_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input logic td, input logic we, input logic inj,
                      input logic wen, input logic [1:0] a, input logic [15:0] wd);
    @(negedge clk);
    evt_test_done = td; evt_wr_err = we; evt_wr_inj = inj;
    reg_wen = wen; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    evt_test_done = 1'b0; evt_wr_err = 1'b0; evt_wr_inj = 1'b0;
    reg_wen = 1'b0; reg_wdata = 16'h0000;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); check("R1 first after reset", d, 16'h0000);
    rd(2'd1, d); check("R1 accumulate after reset", d, 16'h0000);
    rd(2'd2, d); check("R1 mask after reset", d, 16'h0000);
    check("R1 nf after reset", {15'd0, nf_err}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].td, VEC[i].we, VEC[i].inj, VEC[i].wen, VEC[i].addr, VEC[i].wdata);
      check($sformatf("R9 nf vector %0d", i), {15'd0, nf_err}, {15'd0, VEC[i].exp_nf});
      rd(2'd0, d); check($sformatf("R2 first vector %0d", i), d, VEC[i].exp_first);
      rd(2'd1, d); check($sformatf("R3 accumulate vector %0d", i), d, VEC[i].exp_next);
    end

    // R7 mask read/write, reserved bits read zero
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'hFFFF);
    rd(2'd2, d); check("R7 mask readback", d, 16'h00C0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000);
    check("R7 masked nf", {15'd0, nf_err}, 16'h0000);
    rd(2'd0, d); check("R7 masked first", d, 16'h0040);
    rd(2'd1, d); check("R7 masked accumulate", d, 16'h0000);

    // R6 warm reset: events and writes ignored, logs kept, mask cleared
    @(negedge clk);
    warm_rst = 1'b1; evt_test_done = 1'b1;
    reg_wen = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0040;
    @(negedge clk);
    warm_rst = 1'b0; evt_test_done = 1'b0; reg_wen = 1'b0; reg_wdata = 16'h0000;
    check("R6 nf after warm", {15'd0, nf_err}, 16'h0000);
    rd(2'd0, d); check("R6 first kept", d, 16'h0040);
    rd(2'd1, d); check("R6 accumulate kept", d, 16'h0000);
    rd(2'd2, d); check("R6 mask cleared", d, 16'h0000);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000);
    rd(2'd1, d); check("R3 event after warm", d, 16'h0080);
    check("R9 nf after warm event", {15'd0, nf_err}, 16'h0001);

    // R1 power-on reset clears the logs
    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    rd(2'd0, d); check("R1 first after por", d, 16'h0000);
    rd(2'd1, d); check("R1 accumulate after por", d, 16'h0000);

    // R2 two sources in one cycle both land in first
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000);
    rd(2'd0, d); check("R2 simultaneous first", d, 16'h00C0);
    rd(2'd1, d); check("R2 simultaneous accumulate", d, 16'h0000);

    // R4 unused address
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 16'hFFFF);
    rd(2'd3, d); check("R4 unused address", d, 16'h0000);
    rd(2'd0, d); check("R4 first untouched by addr 3", d, 16'h00C0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule